// File: doc/BRIEF.md
# Split Direct/Indirect Internal Data Memory

This block is the internal data store of a small 8-bit controller. It holds 256 bytes of RAM as two 128-byte banks. Every access carries a byte address and an addressing mode. The block uses these two inputs to route the access to RAM or to an external special-function-register (SFR) bank. Addresses in the low half always reach the lower RAM bank. In the high half, two physically separate spaces share the same addresses. A direct access there goes out through the SFR port. An indirect or stack access there lands in the upper RAM bank.

A built-in stack pointer serves push and pop operations. Because the stack is addressed indirectly, it can grow into the upper RAM bank. The SFR port presents the address, write data and a write flag with a request strobe. The SFR bank returns read data in the same cycle, and the block forwards it to its own read output. Read data is combinational in the cycle of the request. Writes and stack-pointer updates take effect at the next rising clock edge.

Top module: `idata_space`

## Requirements
- R1: During and after a synchronous active-low reset, `stack_ptr` is 07H and `sfr_req` is low.
- R2: With `acc_mode` = 2'b00 (direct) and an address in 00H–7FH, a write stores the byte in lower RAM and a read returns it in the same cycle. `sfr_req` stays low.
- R3: With `acc_mode` = 2'b01 (indirect), an address in 00H–7FH reaches the same lower RAM byte that a direct access at that address reaches.
- R4: A direct access at 80H–FFH raises `sfr_req` and drives `sfr_addr`, `sfr_wr` and `sfr_wdata` from the access. `acc_rdata` then equals `sfr_rdata` in the same cycle, and upper RAM is not written.
- R5: An indirect access at 80H–FFH reads or writes upper RAM, keeps `sfr_req` low, and is unaffected by `sfr_rdata`.
- R6: With `acc_mode` = 2'b10 (push), the stack pointer increments and `acc_wdata` is written at the incremented address. The new pointer is visible on `stack_ptr` after the edge.
- R7: With `acc_mode` = 2'b11 (pop), `acc_rdata` returns the byte at the current stack pointer in the same cycle, and the pointer then decrements.
- R8: The stack pointer wraps modulo 256: a push at FFH writes address 00H, and a pop at 00H leaves FFH.
- R9: Stack accesses are indirect. They never raise `sfr_req`, and bytes pushed at 80H or above are read back by indirect but not by direct accesses.
- R10: With `acc_valid` low, nothing is written, `sfr_req` stays low and `stack_ptr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_mode | input | 2 | 00 direct, 01 indirect, 10 push, 11 pop |
| acc_addr | input | 8 | Byte address for direct and indirect modes |
| acc_wr | input | 1 | Write for direct and indirect modes |
| acc_wdata | input | 8 | Write or push data |
| acc_rdata | output | 8 | Read or pop data, same cycle |
| stack_ptr | output | 8 | Current stack pointer |
| sfr_req | output | 1 | SFR access strobe |
| sfr_wr | output | 1 | SFR write flag |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, same cycle |

## Verification
The bench writes a distinct arithmetic pattern through the direct path into every lower-RAM byte and reads each byte back through the indirect path. This shows that the low half is one shared store. It then fills every upper byte indirectly and issues a direct write and a direct read at each of the 128 high addresses. The SFR side returns an address-derived value, so the checks separate an access that leaked into RAM from one correctly routed out. A later indirect sweep confirms that the upper RAM survived the direct writes. A stack run pushes enough bytes to climb from 07H through the upper bank to FFH, then wraps past 00H and pops back. This separates pre-increment from post-increment, LIFO order, wrap-around, and stack placement in the indirect space.

// File: rtl/idata_pkg.sv
// Package: shared types and encodings for the split data memory.
// Assumes: two address halves, top address bit selects the half.
package idata_pkg;

    // Access mode encoding as seen on the acc_mode port.
    typedef enum logic [1:0] {
        AM_DIRECT   = 2'b00,
        AM_INDIRECT = 2'b01,
        AM_PUSH     = 2'b10,
        AM_POP      = 2'b11
    } acc_mode_e;

    // True when the mode goes through the stack pointer.
    function automatic logic is_stack(acc_mode_e m);
        return (m == AM_PUSH) || (m == AM_POP);
    endfunction

endpackage

// File: rtl/idata_route.sv
// Module: idata_route
// Computes the effective address of an access and decides its target.
// A direct access in the upper half goes out to the SFR port.
// Every other valid access goes to RAM.
// Assumes: the stack pointer is the one held before the current edge.
module idata_route
    import idata_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              acc_valid,
    input  acc_mode_e         mode,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              to_sfr,
    output logic              ram_we,
    output logic              sp_inc,
    output logic              sp_dec
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic upper_half;

    // Effective address: pre-incremented pointer for push, pointer for pop.
    always_comb begin
        unique case (mode)
            AM_PUSH: eff_addr = sp + ONE;
            AM_POP:  eff_addr = sp;
            default: eff_addr = acc_addr;
        endcase
    end

    // Top address bit picks the half where SFR and RAM overlap.
    always_comb upper_half = eff_addr[ADDR_W-1];

    // Target decision: only direct mode in the upper half leaves the block.
    always_comb to_sfr = acc_valid && (mode == AM_DIRECT) && upper_half;

    // RAM write enable: push always writes, plain modes follow acc_wr.
    always_comb begin
        ram_we = 1'b0;
        if (acc_valid && !to_sfr) begin
            if (mode == AM_PUSH)
                ram_we = 1'b1;
            else if (!is_stack(mode))
                ram_we = acc_wr;
        end
    end

    // Stack pointer moves only on valid stack operations.
    always_comb begin
        sp_inc = acc_valid && (mode == AM_PUSH);
        sp_dec = acc_valid && (mode == AM_POP);
    end

endmodule

// File: rtl/idata_bank.sv
// Module: idata_bank
// One RAM bank with synchronous write and combinational read.
// Assumes: no reset of contents; unwritten bytes are undefined.
module idata_bank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a byte on an enabled edge.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Read the addressed byte in the same cycle.
    always_comb rdata = mem[addr];

endmodule

// File: rtl/idata_stackptr.sv
// Module: idata_stackptr
// Stack pointer register that moves by one per push or pop.
// Assumes: push and pop are never requested together; wraps at 2**ADDR_W.
module idata_stackptr #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // Pointer update: reset value, then plus or minus one, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= SP_RESET;
        else if (inc)
            sp <= sp + STEP;
        else if (dec)
            sp <= sp - STEP;
    end

endmodule

// File: rtl/idata_space.sv
// Module: idata_space (top)
// Internal data memory: two RAM banks, a stack pointer, and a port
// to an external SFR bank that shares the upper address half.
// Assumes: the SFR bank answers reads combinationally in the same cycle.
module idata_space
    import idata_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_mode,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [ADDR_W-1:0] stack_ptr,
    output logic              sfr_req,
    output logic              sfr_wr,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);

    localparam int BANK_AW   = ADDR_W - 1;
    localparam int NUM_BANKS = 2;

    acc_mode_e         mode;
    logic [ADDR_W-1:0] eff_addr;
    logic              to_sfr;
    logic              ram_we;
    logic              sp_inc;
    logic              sp_dec;
    logic [ADDR_W-1:0] sp;
    logic              bank_sel;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] ram_rdata;

    // Decode the raw mode bits into the shared enum.
    always_comb mode = acc_mode_e'(acc_mode);

    idata_route #(.ADDR_W(ADDR_W)) u_route (
        .acc_valid (acc_valid),
        .mode      (mode),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .sp        (sp),
        .eff_addr  (eff_addr),
        .to_sfr    (to_sfr),
        .ram_we    (ram_we),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec)
    );

    idata_stackptr #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp)
    );

    // Bank select is the top bit of the effective address.
    always_comb bank_sel = eff_addr[ADDR_W-1];

    // One bank per address half; each sees only its own write enable.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        always_comb bank_we = ram_we && (bank_sel == 1'(b));
        idata_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
            .clk   (clk),
            .we    (bank_we),
            .addr  (eff_addr[BANK_AW-1:0]),
            .wdata (acc_wdata),
            .rdata (bank_rd[b])
        );
    end

    // Pick the read data of the addressed bank.
    always_comb ram_rdata = bank_rd[bank_sel];

    // Read mux: SFR answer for routed accesses, RAM otherwise.
    always_comb acc_rdata = to_sfr ? sfr_rdata : ram_rdata;

    // SFR port: strobe and write flag gated, address and data passed on.
    always_comb begin
        sfr_req   = to_sfr;
        sfr_wr    = to_sfr && acc_wr;
        sfr_addr  = acc_addr;
        sfr_wdata = acc_wdata;
    end

    // Expose the stack pointer.
    always_comb stack_ptr = sp;

endmodule

// File: rtl/idata_space_chk.sv
// Module: idata_space_chk
// Property checker bound to idata_space; observes ports only.
module idata_space_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_mode,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic [DATA_W-1:0] acc_rdata,
    input logic [ADDR_W-1:0] stack_ptr,
    input logic              sfr_req,
    input logic              sfr_wr,
    input logic [DATA_W-1:0] sfr_rdata
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // R1: the pointer leaves reset at its reset value.
    assert_sp_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> stack_ptr == SP_RESET);

    // R4: SFR strobe only for a valid direct access in the upper half.
    assert_sfr_direct_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_req |-> (acc_valid && acc_mode == 2'b00 && acc_addr[ADDR_W-1]));

    // R4: SFR read data reaches the block output in the same cycle.
    assert_sfr_rdata_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_req && !acc_wr) |-> acc_rdata == sfr_rdata);

    // R4: SFR write flag only with the strobe.
    assert_sfr_wr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> sfr_req);

    // R5 and R9: indirect and stack modes never use the SFR port.
    assert_no_sfr_indirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode != 2'b00) |-> !sfr_req);

    // R6: push moves the pointer up by one.
    assert_push_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'b10) |=> stack_ptr == $past(stack_ptr) + ONE);

    // R7: pop moves the pointer down by one.
    assert_pop_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'b11) |=> stack_ptr == $past(stack_ptr) - ONE);

    // R10: without a valid stack operation the pointer holds.
    assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_mode[1]) |=> $stable(stack_ptr));

    // R10: no strobe without a valid access.
    assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !sfr_req);

endmodule

bind idata_space idata_space_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_RESET(SP_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_mode  (acc_mode),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .acc_rdata (acc_rdata),
    .stack_ptr (stack_ptr),
    .sfr_req   (sfr_req),
    .sfr_wr    (sfr_wr),
    .sfr_rdata (sfr_rdata)
);

// File: tb/sim_idata_space.sv
module sim_idata_space;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_mode = 2'b00;
    logic [7:0] acc_addr = 8'h00;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic [7:0] stack_ptr;
    logic       sfr_req;
    logic       sfr_wr;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    int checks = 0;
    int fails = 0;
    logic [7:0] model [256];
    logic [7:0] sp_m;
    logic [7:0] cap_rd;
    logic       cap_req;
    logic       cap_wr;
    logic [7:0] cap_addr;
    logic [7:0] cap_wdata;

    always #5 clk = ~clk;

    // SFR side answers with an address-derived byte.
    assign sfr_rdata = sfr_addr ^ 8'hC3;

    idata_space u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mode(acc_mode),
        .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .stack_ptr(stack_ptr), .sfr_req(sfr_req),
        .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample mid-cycle, commit at posedge.
    task automatic op(input logic v, input logic [1:0] m, input logic [7:0] a,
                      input logic w, input logic [7:0] d);
        @(negedge clk);
        acc_valid = v; acc_mode = m; acc_addr = a; acc_wr = w; acc_wdata = d;
        #1;
        cap_rd = acc_rdata; cap_req = sfr_req; cap_wr = sfr_wr;
        cap_addr = sfr_addr; cap_wdata = sfr_wdata;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 sp in reset", stack_ptr, 8'h07);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 sp after reset", stack_ptr, 8'h07);
        chk("R1 no req", {7'd0, sfr_req}, 8'h00);
        sp_m = 8'h07;

        // R2: direct fill and read of lower RAM
        for (int a = 0; a < 128; a++) begin
            op(1'b1, 2'b00, 8'(a), 1'b1, 8'(a) ^ 8'h5A);
            model[a] = 8'(a) ^ 8'h5A;
            chk("R2 no req on write", {7'd0, cap_req}, 8'h00);
        end
        for (int a = 0; a < 128; a++) begin
            op(1'b1, 2'b00, 8'(a), 1'b0, 8'h00);
            chk("R2 direct read", cap_rd, model[a]);
        end
        // R3: indirect sees the same lower bytes
        for (int a = 0; a < 128; a++) begin
            op(1'b1, 2'b01, 8'(a), 1'b0, 8'h00);
            chk("R3 indirect low read", cap_rd, model[a]);
        end
        // R5: indirect fill of upper RAM
        for (int a = 128; a < 256; a++) begin
            op(1'b1, 2'b01, 8'(a), 1'b1, 8'(a * 3 + 1));
            model[a] = 8'(a * 3 + 1);
            chk("R5 no req indirect write", {7'd0, cap_req}, 8'h00);
        end
        // R4: direct upper accesses go to the SFR port
        for (int a = 128; a < 256; a++) begin
            op(1'b1, 2'b00, 8'(a), 1'b1, 8'hEE);
            chk("R4 req on write", {7'd0, cap_req, cap_wr}, 8'h03);
            chk("R4 sfr addr", cap_addr, 8'(a));
            chk("R4 sfr wdata", cap_wdata, 8'hEE);
            op(1'b1, 2'b00, 8'(a), 1'b0, 8'h00);
            chk("R4 sfr read data", cap_rd, 8'(a) ^ 8'hC3);
            chk("R4 read req no wr", {7'd0, cap_req, cap_wr}, 8'h02);
        end
        // R5: upper RAM untouched by direct writes, sfr_rdata ignored
        for (int a = 128; a < 256; a++) begin
            op(1'b1, 2'b01, 8'(a), 1'b0, 8'h00);
            chk("R5 indirect high read", cap_rd, model[a]);
        end
        // R10: an invalid push-write has no effect
        op(1'b0, 2'b10, 8'h10, 1'b1, 8'h00);
        chk("R10 no req", {7'd0, cap_req}, 8'h00);
        chk("R10 sp holds", stack_ptr, 8'h07);
        op(1'b0, 2'b01, 8'h10, 1'b1, 8'h00);
        op(1'b1, 2'b01, 8'h10, 1'b0, 8'h00);
        chk("R10 byte unchanged", cap_rd, model[16]);

        // R6: three pushes
        for (int i = 0; i < 3; i++) begin
            op(1'b1, 2'b10, 8'h00, 1'b0, 8'hA0 + 8'(i));
            sp_m = sp_m + 8'd1;
            model[sp_m] = 8'hA0 + 8'(i);
            chk("R6 sp after push", stack_ptr, sp_m);
        end
        for (int a = 8; a < 11; a++) begin
            op(1'b1, 2'b01, 8'(a), 1'b0, 8'h00);
            chk("R6 pushed byte placement", cap_rd, model[a]);
        end
        // R7: pops in reverse order
        for (int i = 0; i < 3; i++) begin
            op(1'b1, 2'b11, 8'h00, 1'b0, 8'h00);
            chk("R7 pop data", cap_rd, model[sp_m]);
            sp_m = sp_m - 8'd1;
            chk("R7 sp after pop", stack_ptr, sp_m);
        end

        // R9: climb to FFH through upper RAM
        for (int i = 0; i < 248; i++) begin
            op(1'b1, 2'b10, 8'h00, 1'b0, 8'(i) ^ 8'h96);
            sp_m = sp_m + 8'd1;
            model[sp_m] = 8'(i) ^ 8'h96;
            chk("R9 stack no req", {7'd0, cap_req}, 8'h00);
        end
        chk("R9 sp at top", stack_ptr, 8'hFF);
        op(1'b1, 2'b01, 8'hFF, 1'b0, 8'h00);
        chk("R9 indirect sees stack", cap_rd, model[255]);
        op(1'b1, 2'b01, 8'h80, 1'b0, 8'h00);
        chk("R9 indirect sees stack 80", cap_rd, model[128]);
        op(1'b1, 2'b00, 8'hFF, 1'b0, 8'h00);
        chk("R9 direct goes to sfr", cap_rd, 8'h3C);

        // R8: wrap on push and on pop
        op(1'b1, 2'b10, 8'h00, 1'b0, 8'h5C);
        model[0] = 8'h5C;
        chk("R8 sp wraps to 00", stack_ptr, 8'h00);
        op(1'b1, 2'b00, 8'h00, 1'b0, 8'h00);
        chk("R8 push wrote 00", cap_rd, 8'h5C);
        op(1'b1, 2'b11, 8'h00, 1'b0, 8'h00);
        chk("R8 pop at 00 data", cap_rd, 8'h5C);
        chk("R8 sp wraps to FF", stack_ptr, 8'hFF);
        op(1'b1, 2'b11, 8'h00, 1'b0, 8'h00);
        chk("R8 pop at FF data", cap_rd, model[255]);
        chk("R7 sp to FE", stack_ptr, 8'hFE);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule